// File: doc/BRIEF.md
# Masked Address Window Translator

This block is one outbound memory window between a local processor bus and a 64-bit PCI-style bus. Software programs four registers through a small address/write-enable/data port: a local base address, an attribute word that holds a window mask plus enable and prefetch bits, and the low and high halves of the PCI target address. Each local-bus request is compared against the base under the mask. On a hit the block forms the 64-bit PCI address. It also reports whether the bridge should widen the access into a 64-byte prefetch.

The window mask covers address bits 31:12, so windows are powers of two and at least 4 KB. A small state machine records the window condition. It resets to WIN_OFF. A write of the attribute word with the enable bit clear moves it to WIN_OFF from any state (disable). With the enable bit set and a legal mask it moves to WIN_LIVE: from WIN_OFF this is arm, and from WIN_BAD it is repair. With the enable bit set and an illegal mask it moves to WIN_BAD: from WIN_OFF this is arm-bad, and from WIN_LIVE it is corrupt. Hits are produced only in WIN_LIVE. Software must program the base and both PCI address registers before it sets the enable bit.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset all four registers read 0, mask_bad is 0 and out_valid, out_hit and out_pf are 0.
- R2: In WIN_LIVE, a request hits exactly when its address equals the base address on every bit where the 20-bit mask field (attribute bits 31:12) is 1.
- R3: While the enable bit (attribute bit 0) is 0, no request hits.
- R4: On a hit, PCI address bits 31:0 take the PCI-low bits where the mask is 1 and the request address bits elsewhere. Bits 11:0 always come from the request, and bits 63:32 equal the PCI-high register. On a miss the PCI address output is 0.
- R5: out_pf is 1 only for a hit that is a read of kind 0 (single beat), 1 (byte burst) or 2 (halfword burst) while the prefetch bit (attribute bit 1) is 1. Writes and kind 3 (word burst) never set it.
- R6: Attribute bits 11:2 always read as 0, whatever was written.
- R7: A mask that is not ones followed by zeros is stored and read back as written. mask_bad then reads 1, and no request hits until a legal mask is written.
- R8: out_valid, out_hit, out_pci_addr and out_pf are registered and appear on the clock edge after the edge that samples req_valid.
- R9: Mask 0xFFFFF gives a 4 KB window that matches only its own page. Mask 0xF8000 gives a 128 MB window.
- R10: Register addresses are 0 local base, 1 attribute, 2 PCI low, 3 PCI high. Writes take effect at the clock edge with reg_we high, and reg_rdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Local request valid |
| req_addr | input | 32 | Local request address |
| req_read | input | 1 | 1 for read, 0 for write |
| req_kind | input | 2 | 0 single, 1 byte burst, 2 halfword burst, 3 word burst |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Request falls in the window |
| out_pci_addr | output | 64 | Translated PCI address |
| out_pf | output | 1 | Request a 64-byte prefetch |
| mask_bad | output | 1 | Stored mask is not contiguous |

## Verification
Each request result is due one clock after the edge that accepts it. The driver pushes its expected item when it raises req_valid. The monitor pops one item each time out_valid is high, sampling just after the falling edge that follows the result edge. Register writes and mask_bad take effect at the write edge, so reads and mask_bad checks are sampled at the next falling edge. No request is issued in the same cycle as a register write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        WIN_OFF  = 2'd0,
        WIN_LIVE = 2'd1,
        WIN_BAD  = 2'd2
    } win_state_t;

    typedef enum logic [1:0] {
        KIND_SINGLE     = 2'd0,
        KIND_BYTE_BURST = 2'd1,
        KIND_HALF_BURST = 2'd2,
        KIND_WORD_BURST = 2'd3
    } req_kind_t;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_ATTR  = 2'd1;
    localparam logic [1:0] REG_PCILO = 2'd2;
    localparam logic [1:0] REG_PCIHI = 2'd3;
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 reg_addr,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_wdata,
    output logic [ADDR_W-1:0]          reg_rdata,
    output logic [ADDR_W-1:0]          base_q,
    output logic [ADDR_W-PAGE_BITS-1:0] mask_q,
    output logic                       pf_q,
    output logic [ADDR_W-1:0]          pcilo_q,
    output logic [ADDR_W-1:0]          pcihi_q,
    output win_state_t                 state_q,
    output logic                       mask_bad
);
    localparam int MASK_W = ADDR_W - PAGE_BITS;
    localparam logic [MASK_W-1:0] M_ONE = {{(MASK_W-1){1'b0}}, 1'b1};

    function automatic logic mask_ok(input logic [MASK_W-1:0] m);
        logic [MASK_W-1:0] inv;
        inv = ~m;
        return ((inv & (inv + M_ONE)) == '0);
    endfunction

    logic       en_q;
    win_state_t state_d;
    logic       attr_wr;

    assign attr_wr = reg_we && (reg_addr == REG_ATTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mask_q  <= '0;
            pf_q    <= 1'b0;
            en_q    <= 1'b0;
            pcilo_q <= '0;
            pcihi_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                REG_BASE:  base_q  <= reg_wdata;
                REG_ATTR: begin
                    mask_q <= reg_wdata[ADDR_W-1:PAGE_BITS];
                    pf_q   <= reg_wdata[1];
                    en_q   <= reg_wdata[0];
                end
                REG_PCILO: pcilo_q <= reg_wdata;
                REG_PCIHI: pcihi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // window condition: next state
    always_comb begin
        state_d = state_q;
        if (attr_wr) begin
            unique case (state_q)
                WIN_OFF, WIN_LIVE, WIN_BAD: begin
                    if (!reg_wdata[0])
                        state_d = WIN_OFF;
                    else if (mask_ok(reg_wdata[ADDR_W-1:PAGE_BITS]))
                        state_d = WIN_LIVE;
                    else
                        state_d = WIN_BAD;
                end
                default: state_d = WIN_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WIN_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        mask_bad = !mask_ok(mask_q);
        unique case (reg_addr)
            REG_BASE:  reg_rdata = base_q;
            REG_ATTR:  reg_rdata = {mask_q, {(PAGE_BITS-2){1'b0}}, pf_q, en_q};
            REG_PCILO: reg_rdata = pcilo_q;
            REG_PCIHI: reg_rdata = pcihi_q;
            default:   reg_rdata = '0;
        endcase
    end

    // R7
    live_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_LIVE) |-> !mask_bad);

    // R3
    off_when_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (state_q == WIN_OFF));
endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_read,
    input  logic [1:0]                  req_kind,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ADDR_W-PAGE_BITS-1:0] mask,
    input  logic                        pf_en,
    input  logic                        live,
    input  logic [ADDR_W-1:0]           pci_lo,
    input  logic [ADDR_W-1:0]           pci_hi,
    output logic                        out_valid,
    output logic                        out_hit,
    output logic [2*ADDR_W-1:0]         out_pci_addr,
    output logic                        out_pf
);
    logic [ADDR_W-1:0]   mask_full;
    logic                hit_c;
    logic                small_rd;
    logic [2*ADDR_W-1:0] xl_addr;

    always_comb begin
        mask_full = {mask, {PAGE_BITS{1'b0}}};
        hit_c     = req_valid && live && (((req_addr ^ base) & mask_full) == '0);
        small_rd  = req_read && (req_kind != KIND_WORD_BURST);
        xl_addr   = {pci_hi, (pci_lo & mask_full) | (req_addr & ~mask_full)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_hit      <= 1'b0;
            out_pci_addr <= '0;
            out_pf       <= 1'b0;
        end else begin
            out_valid    <= req_valid;
            out_hit      <= hit_c;
            out_pci_addr <= hit_c ? xl_addr : '0;
            out_pf       <= hit_c && pf_en && small_rd;
        end
    end

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(req_valid));

    // R4
    low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_pci_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

    // R5
    pf_hit_chk: assert property (@(posedge clk) disable iff (rst)
        out_pf |-> (out_hit && $past(req_read)));
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import xlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          reg_addr,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_wdata,
    output logic [ADDR_W-1:0]   reg_rdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_read,
    input  logic [1:0]          req_kind,
    output logic                out_valid,
    output logic                out_hit,
    output logic [2*ADDR_W-1:0] out_pci_addr,
    output logic                out_pf,
    output logic                mask_bad
);
    localparam int MASK_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0] base_q, pcilo_q, pcihi_q;
    logic [MASK_W-1:0] mask_q;
    logic              pf_q;
    win_state_t        state_q;

    xlat_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .base_q(base_q), .mask_q(mask_q), .pf_q(pf_q),
        .pcilo_q(pcilo_q), .pcihi_q(pcihi_q),
        .state_q(state_q), .mask_bad(mask_bad)
    );

    xlat_match #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_match (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_kind(req_kind),
        .base(base_q), .mask(mask_q), .pf_en(pf_q),
        .live(state_q == WIN_LIVE),
        .pci_lo(pcilo_q), .pci_hi(pcihi_q),
        .out_valid(out_valid), .out_hit(out_hit),
        .out_pci_addr(out_pci_addr), .out_pf(out_pf)
    );

    // R2
    hit_live_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> ($past(state_q) == WIN_LIVE));

    // R7
    bad_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> !$past(mask_bad));
endmodule

// File: tb/addr_window_xlat_test.sv
module addr_window_xlat_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_read = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        out_valid, out_hit, out_pf, mask_bad;
    logic [63:0] out_pci_addr;

    typedef struct {
        logic        hit;
        logic [63:0] addr;
        logic        pf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    logic [31:0] m_base = 0, m_attr = 0, m_plo = 0, m_phi = 0;

    always #4 clk = ~clk;

    addr_window_xlat uut (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_kind(req_kind),
        .out_valid(out_valid), .out_hit(out_hit),
        .out_pci_addr(out_pci_addr), .out_pf(out_pf),
        .mask_bad(mask_bad)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit legal_model(input logic [19:0] m);
        bit seen_zero = 0;
        for (int i = 19; i >= 0; i--) begin
            if (!m[i]) seen_zero = 1;
            else if (seen_zero) return 0;
        end
        return 1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        case (a)
            2'd0: m_base = d;
            2'd1: m_attr = {d[31:12], 10'b0, d[1:0]};
            2'd2: m_plo = d;
            default: m_phi = d;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, req, 64'(reg_rdata), 64'(e));
    endtask

    task automatic send(input logic [31:0] a, input logic r, input logic [1:0] k,
                        input string tag);
        exp_t e;
        logic [31:0] mf;
        bit h;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_read = r; req_kind = k;
        mf = {m_attr[31:12], 12'h000};
        h = m_attr[0] && legal_model(m_attr[31:12]) && (((a ^ m_base) & mf) == 0);
        e.hit  = h;
        e.addr = h ? {m_phi, (m_plo & mf) | (a & ~mf)} : 64'h0;
        e.pf   = h && m_attr[1] && r && (k != 2'd3);
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops one expected item per result
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected result", 64'(out_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_hit == e.hit, {e.tag, " hit"}, 64'(out_hit), 64'(e.hit));
                    chk(out_pci_addr == e.addr, {e.tag, " addr"}, out_pci_addr, e.addr);
                    chk(out_pf == e.pf, {e.tag, " pf"}, 64'(out_pf), 64'(e.pf));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(2'(i), 32'h0, "R1 reset reg");
        chk(mask_bad == 1'b0, "R1 mask_bad", 64'(mask_bad), 64'd0);
        chk(out_valid == 1'b0 && out_hit == 1'b0 && out_pf == 1'b0,
            "R1 outputs", {61'b0, out_valid, out_hit, out_pf}, 64'd0);

        // R6 reserved bits, R10 readback
        wr(2'd1, 32'hFFFF_FFFE);
        rd(2'd1, 32'hFFFF_F002, "R6 reserved zero");
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h4000_0000);
        wr(2'd2, 32'h9000_0000);
        wr(2'd3, 32'h0000_0012);
        rd(2'd0, 32'h4000_0000, "R10 base readback");
        rd(2'd2, 32'h9000_0000, "R10 pcilo readback");
        rd(2'd3, 32'h0000_0012, "R10 pcihi readback");

        // R3 disabled window with matching address
        wr(2'd1, 32'hF800_0002);
        send(32'h4123_4567, 1'b1, 2'd0, "R3 disabled");

        // R9 128MB window, R2 R4 R5
        wr(2'd1, 32'hF800_0003);
        send(32'h4123_4567, 1'b1, 2'd0, "R2 R4 R9 hit single");
        send(32'h47FF_FFFC, 1'b1, 2'd1, "R9 top of window");
        send(32'h4800_0000, 1'b1, 2'd0, "R9 past window");
        send(32'h3FFF_FFFC, 1'b1, 2'd2, "R2 below window");
        send(32'h4000_1000, 1'b0, 2'd0, "R5 write no pf");
        send(32'h4000_2000, 1'b1, 2'd3, "R5 word burst no pf");
        send(32'h4000_3000, 1'b1, 2'd2, "R5 half burst pf");
        wr(2'd1, 32'hF800_0001);
        send(32'h4000_3000, 1'b1, 2'd1, "R5 pf disabled");

        // R9 4KB window
        wr(2'd0, 32'h1234_5000);
        wr(2'd2, 32'hABCD_E000);
        wr(2'd1, 32'hFFFF_F003);
        send(32'h1234_5FFC, 1'b1, 2'd0, "R9 4KB hit");
        send(32'h1234_6000, 1'b1, 2'd0, "R9 4KB next page");
        send(32'h1234_4FFF, 1'b1, 2'd0, "R9 4KB prev page");

        // R7 illegal mask
        wr(2'd1, 32'hF0F0_0003);
        rd(2'd1, 32'hF0F0_0003, "R7 stored as written");
        chk(mask_bad == 1'b1, "R7 mask_bad set", 64'(mask_bad), 64'd1);
        send(32'h1234_5000, 1'b1, 2'd0, "R7 suppressed");
        wr(2'd1, 32'hFF00_0003);
        chk(mask_bad == 1'b0, "R7 mask_bad clear", 64'(mask_bad), 64'd0);
        send(32'h1234_5678, 1'b1, 2'd0, "R7 repaired hit");

        // R8 back-to-back results drain
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule